// File: doc/BRIEF.md
# SDRAM Device-Side Command and Bank Tracker

This block watches the pins of a single-data-rate SDRAM from the device side. It works on a four-bank part with a 32-bit data path. On every rising clock edge it samples chip select, the three command strobes, the 13-bit address, the two bank-select pins, the clock enable and the four byte masks. It turns the strobe levels into a command and reports that command on a one-cycle decoded strobe. It keeps an open or closed flag for each bank, and it holds the row that opened each bank.

A legal read or write captures the starting column of the burst and the bank it targets. The byte masks drive two lane-enable vectors with different latencies. Write-lane enables follow the masks in the same cycle. Read-lane output enables follow the masks two valid edges later.

Misuse of a bank sets a sticky protocol-error flag and leaves the bank state alone. There are three kinds of misuse: a read to a closed bank, a write to a closed bank, and an activate to a bank that is already open. The block is meant to sit beside a memory model or a controller under test. It gives the bench a decoded view of the pin traffic.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is held low, and just after it is released, all banks read closed. All command strobes, proto_err, rd_lane_oe and burst_col read zero.
- R2: An edge that samples cs_n high accepts no command. No strobe pulses and no bank state changes.
- R3: On a valid edge with cs_n low, the command follows {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode-register set, 111 no-operation. The matching strobe, one of cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref or cmd_mrs, is high for exactly the one cycle after that edge.
- R4: An activate to a closed bank sets bank_open for that bank. It also latches addr[12:0] into that bank's 13-bit field of open_row, which sits at bits [13*b+12:13*b] for bank b.
- R5: The bank number is {ba0,ba1}, with ba0 as the high bit. So ba0=0,ba1=1 selects bank 1 and ba0=1,ba1=0 selects bank 2.
- R6: A precharge with addr[10]=1 closes all four banks. A precharge with addr[10]=0 closes only the selected bank.
- R7: A legal read or write loads burst_col with addr[9:0] and burst_bank with the selected bank number.
- R8: If cke is sampled low at an edge, the following edge is ignored. It pulses no strobe, changes no bank or error state, and does not advance the read-mask pipeline.
- R9: rd_lane_oe[i] equals the inverse of dqm[i] sampled two valid edges earlier. It changes just after the second of those edges.
- R10: In a cycle that presents a legal write on a valid edge, wr_lane_en[i] is high exactly when dqm[i] is low. It follows dqm combinationally in that same cycle. In every other cycle wr_lane_en is zero.
- R11: A read or write to a closed bank, or an activate to an open bank, sets proto_err. proto_err then stays high until reset. The illegal command changes neither bank_open, nor open_row, nor burst_col.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low-active |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| addr | input | 13 | Address bus: row on activate, column on read or write, bit 10 all-bank flag on precharge |
| ba0 | input | 1 | Bank select, high bit of the bank number |
| ba1 | input | 1 | Bank select, low bit of the bank number |
| cke | input | 1 | Clock enable; when sampled low, the next edge is invalid |
| dqm | input | 4 | Byte masks, one per data byte lane |
| cmd_act | output | 1 | Activate accepted on the last edge |
| cmd_rd | output | 1 | Read accepted on the last edge |
| cmd_wr | output | 1 | Write accepted on the last edge |
| cmd_pre | output | 1 | Precharge accepted on the last edge |
| cmd_ref | output | 1 | Auto-refresh accepted on the last edge |
| cmd_mrs | output | 1 | Mode-register set accepted on the last edge |
| bank_open | output | 4 | Open flag per bank |
| open_row | output | 52 | Latched row per bank, 13 bits each, bank 0 lowest |
| burst_col | output | 10 | Start column of the last legal read or write |
| burst_bank | output | 2 | Bank of the last legal read or write |
| wr_lane_en | output | 4 | Per-lane write enable, same cycle as the masks |
| rd_lane_oe | output | 4 | Per-lane read output enable, two valid edges behind the masks |
| proto_err | output | 1 | Sticky bank-misuse flag |

## Verification
The bench checks each bank-select pattern on its own. A design that swapped the two bank pins would open bank 2 where bank 1 was asked for. It issues a precharge with chip select high and with clock enable just dropped. A design that did not ignore those edges would close banks that must stay open. It also shows whether suspend freezes the read-mask pipeline: a design that kept shifting would turn the lanes off one cycle early. It drives mixed mask patterns so that a one-cycle or three-cycle read latency shows up as the wrong lane vector. It sends an illegal read to a closed bank and a second activate to an open bank. It checks that the error stays set and that the latched row and column are untouched.

// File: rtl/sdram_trk_pkg.sv
// Shared definitions for the SDRAM command and bank tracker.
// Assumes a four-bank, single-data-rate part; pin codes are low-active
// {ras_n,cas_n,we_n} levels sampled with cs_n low.
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_DESEL
    } cmd_e;

    localparam logic [2:0] PIN_ACT = 3'b011;
    localparam logic [2:0] PIN_RD  = 3'b101;
    localparam logic [2:0] PIN_WR  = 3'b100;
    localparam logic [2:0] PIN_PRE = 3'b010;
    localparam logic [2:0] PIN_REF = 3'b001;
    localparam logic [2:0] PIN_MRS = 3'b000;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: maps chip select and the three strobe pins to a command.
// Purely combinational; codes not in the table are treated as no-operation.
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Decode the pin levels into one command value.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                PIN_ACT: cmd = CMD_ACT;
                PIN_RD:  cmd = CMD_RD;
                PIN_WR:  cmd = CMD_WR;
                PIN_PRE: cmd = CMD_PRE;
                PIN_REF: cmd = CMD_REF;
                PIN_MRS: cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_state.sv
// Per-bank open flag and latched row. Flags misuse (column access to a
// closed bank, activate to an open bank) without touching the state.
// Assumes edge_ok already folds in the clock-enable gating.
module sdram_bank_state
    import sdram_trk_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ROW_W = 13,
    localparam int BA_W = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edge_ok,
    input  cmd_e                   cmd,
    input  logic [BA_W-1:0]        bank_sel,
    input  logic [ROW_W-1:0]       row_in,
    input  logic                   pre_all,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_row,
    output logic                   illegal
);

    logic             sel_open;
    logic [ROW_W-1:0] row_q [NBANK];

    // Current open state of the addressed bank.
    assign sel_open = bank_open[bank_sel];

    // Misuse of the addressed bank under the current command.
    always_comb begin
        illegal = 1'b0;
        if ((cmd == CMD_RD || cmd == CMD_WR) && !sel_open) illegal = 1'b1;
        if (cmd == CMD_ACT && sel_open)                     illegal = 1'b1;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (bank_sel == BA_W'(b));

        // Open flag and row register of one bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                row_q[b]     <= '0;
            end else if (edge_ok) begin
                if (cmd == CMD_ACT && hit && !bank_open[b]) begin
                    bank_open[b] <= 1'b1;
                    row_q[b]     <= row_in;
                end else if (cmd == CMD_PRE && (pre_all || hit)) begin
                    bank_open[b] <= 1'b0;
                end
            end
        end

        assign open_row[b*ROW_W +: ROW_W] = row_q[b];
    end

endmodule

// File: rtl/sdram_mask_pipe.sv
// Read-mask latency line: carries the inverted byte masks through DEPTH
// stages that shift only on valid edges. DEPTH of zero is a plain wire.
module sdram_mask_pipe #(
    parameter int LANES = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] lane_oe
);

    if (DEPTH == 0) begin : g_wire
        assign lane_oe = ~mask;
    end else begin : g_pipe
        logic [LANES-1:0] stg [DEPTH];

        // Shift the inverted masks one stage per valid edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else if (adv) begin
                stg[0] <= ~mask;
                for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
        end

        assign lane_oe = stg[DEPTH-1];
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top level of the device-side SDRAM command and bank tracker.
// Samples the pins on each rising edge, gates edges with the clock enable
// registered on the previous edge, decodes commands into one-cycle strobes,
// tracks banks, captures the burst start and forms the byte-lane enables.
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int LANES  = 4,
    parameter int RD_LAT = 2,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [ROW_W-1:0]       addr,
    input  logic                   ba0,
    input  logic                   ba1,
    input  logic                   cke,
    input  logic [LANES-1:0]       dqm,
    output logic                   cmd_act,
    output logic                   cmd_rd,
    output logic                   cmd_wr,
    output logic                   cmd_pre,
    output logic                   cmd_ref,
    output logic                   cmd_mrs,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_row,
    output logic [COL_W-1:0]       burst_col,
    output logic [BA_W-1:0]        burst_bank,
    output logic [LANES-1:0]       wr_lane_en,
    output logic [LANES-1:0]       rd_lane_oe,
    output logic                   proto_err
);

    cmd_e            cmd;
    logic            cke_q;
    logic            edge_ok;
    logic            illegal;
    logic [BA_W-1:0] bank_sel;

    assign bank_sel = {ba0, ba1};
    assign edge_ok  = cke_q;

    // Clock enable seen on this edge decides whether the next edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_bank_state #(.NBANK(NBANK), .ROW_W(ROW_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_ok   (edge_ok),
        .cmd       (cmd),
        .bank_sel  (bank_sel),
        .row_in    (addr),
        .pre_all   (addr[AP_BIT]),
        .bank_open (bank_open),
        .open_row  (open_row),
        .illegal   (illegal)
    );

    sdram_mask_pipe #(.LANES(LANES), .DEPTH(RD_LAT)) u_rdmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (edge_ok),
        .mask    (dqm),
        .lane_oe (rd_lane_oe)
    );

    // One-cycle decoded command strobes for accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n || !edge_ok) begin
            {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs} <= '0;
        end else begin
            cmd_act <= (cmd == CMD_ACT);
            cmd_rd  <= (cmd == CMD_RD);
            cmd_wr  <= (cmd == CMD_WR);
            cmd_pre <= (cmd == CMD_PRE);
            cmd_ref <= (cmd == CMD_REF);
            cmd_mrs <= (cmd == CMD_MRS);
        end
    end

    // Burst start column and bank of the last legal column access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_col  <= '0;
            burst_bank <= '0;
        end else if (edge_ok && (cmd == CMD_RD || cmd == CMD_WR) && !illegal) begin
            burst_col  <= addr[COL_W-1:0];
            burst_bank <= bank_sel;
        end
    end

    // Sticky protocol-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  proto_err <= 1'b0;
        else if (edge_ok && illegal) proto_err <= 1'b1;
    end

    // Write lanes follow the masks in the write cycle itself.
    assign wr_lane_en = (edge_ok && cmd == CMD_WR && !illegal) ? ~dqm : '0;

endmodule

// File: rtl/sdram_trk_checker.sv
// Property checker for the SDRAM command tracker, bound to the top level.
// Observes only top-level ports; a saturating counter gates checks that
// look back further than the cycles since reset.
module sdram_trk_checker #(
    parameter int NBANK = 4,
    parameter int LANES = 4,
    parameter int ROW_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cke,
    input logic [ROW_W-1:0] addr,
    input logic             ba0,
    input logic             ba1,
    input logic [LANES-1:0] dqm,
    input logic             cmd_act,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic             cmd_pre,
    input logic             cmd_ref,
    input logic             cmd_mrs,
    input logic [NBANK-1:0] bank_open,
    input logic [LANES-1:0] wr_lane_en,
    input logic [LANES-1:0] rd_lane_oe,
    input logic             proto_err
);

    logic [2:0] since;
    logic       any_stb;

    assign any_stb = cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs;

    // Cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)        since <= '0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    assert_cs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !any_stb);

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs}));

    assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd2 && cmd_act && !proto_err) |-> bank_open[{$past(ba0), $past(ba1)}]);

    assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd2 && cmd_pre && $past(addr[10])) |-> (bank_open == '0));

    assert_suspend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd1 && !cke) |=> ##1 ($stable(bank_open) && $stable(proto_err) && !any_stb));

    assert_rd_mask_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd4 && $past(cke, 2) && $past(cke, 3)) |-> (rd_lane_oe == ~$past(dqm, 2)));

    assert_wr_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lane_en & dqm) == '0);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind sdram_cmd_tracker sdram_trk_checker #(
    .NBANK(NBANK), .LANES(LANES), .ROW_W(ROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cke        (cke),
    .addr       (addr),
    .ba0        (ba0),
    .ba1        (ba1),
    .dqm        (dqm),
    .cmd_act    (cmd_act),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .cmd_pre    (cmd_pre),
    .cmd_ref    (cmd_ref),
    .cmd_mrs    (cmd_mrs),
    .bank_open  (bank_open),
    .wr_lane_en (wr_lane_en),
    .rd_lane_oe (rd_lane_oe),
    .proto_err  (proto_err)
);

// File: tb/tb_sdram_cmd_tracker.sv
// Self-checking bench: a vector table of commands with expected bank state
// and strobes, then directed tests for masks, suspend, misuse and reset.
module tb_sdram_cmd_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [12:0] addr;
    logic        ba0, ba1, cke;
    logic [3:0]  dqm;
    logic        cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs;
    logic [3:0]  bank_open;
    logic [51:0] open_row;
    logic [9:0]  burst_col;
    logic [1:0]  burst_bank;
    logic [3:0]  wr_lane_en, rd_lane_oe;
    logic        proto_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                           C_NOP = 3'b111;

    // {cs_n, cmd[2:0], ba0, ba1, addr[12:0], exp_open[3:0], exp_stb[5:0]}
    // exp_stb order: act, rd, wr, pre, ref, mrs
    localparam int NVEC = 12;
    localparam logic [28:0] VECS [NVEC] = '{
        {1'b0, C_ACT, 2'b01, 13'h00AA, 4'b0010, 6'b100000},
        {1'b0, C_ACT, 2'b10, 13'h0222, 4'b0110, 6'b100000},
        {1'b0, C_ACT, 2'b11, 13'h0333, 4'b1110, 6'b100000},
        {1'b0, C_ACT, 2'b00, 13'h0444, 4'b1111, 6'b100000},
        {1'b0, C_PRE, 2'b10, 13'h0000, 4'b1011, 6'b000100},
        {1'b1, C_PRE, 2'b00, 13'h0400, 4'b1011, 6'b000000},
        {1'b0, C_NOP, 2'b00, 13'h0400, 4'b1011, 6'b000000},
        {1'b0, C_PRE, 2'b00, 13'h0400, 4'b0000, 6'b000100},
        {1'b0, C_REF, 2'b00, 13'h0000, 4'b0000, 6'b000010},
        {1'b0, C_ACT, 2'b01, 13'h1ABC, 4'b0010, 6'b100000},
        {1'b0, C_MRS, 2'b00, 13'h0033, 4'b0010, 6'b000001},
        {1'b0, C_RD,  2'b01, 13'h0010, 4'b0010, 6'b010000}
    };

    sdram_cmd_tracker dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba0(ba0), .ba1(ba1), .cke(cke), .dqm(dqm),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
        .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .bank_open(bank_open),
        .open_row(open_row), .burst_col(burst_col), .burst_bank(burst_bank),
        .wr_lane_en(wr_lane_en), .rd_lane_oe(rd_lane_oe), .proto_err(proto_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Put one command on the pins at the falling edge.
    task automatic drive(input logic c_n, input logic [2:0] c, input logic b0,
                         input logic b1, input logic [12:0] a, input logic [3:0] m,
                         input logic ce);
        @(negedge clk);
        cs_n = c_n; {ras_n, cas_n, we_n} = c; ba0 = b0; ba1 = b1;
        addr = a; dqm = m; cke = ce;
    endtask

    // Wait for the rising edge and settle past it.
    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic step(input logic c_n, input logic [2:0] c, input logic b0,
                        input logic b1, input logic [12:0] a, input logic [3:0] m,
                        input logic ce);
        drive(c_n, c, b0, b1, a, m, ce);
        edge_settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
        addr = '0; ba0 = 1'b0; ba1 = 1'b0; cke = 1'b1; dqm = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while reset is held
        chk("R1 bank_open in reset", 32'(bank_open), 32'h0);
        chk("R1 strobes in reset", 32'({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs}), 32'h0);
        chk("R1 rd_lane_oe in reset", 32'(rd_lane_oe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        edge_settle();
        chk("R1 proto_err after reset", 32'(proto_err), 32'h0);
        chk("R1 burst_col after reset", 32'(burst_col), 32'h0);

        // Table walk: R3 strobes, R5 bank mapping, R6 precharge, R2 deselect
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i][28], VECS[i][27:25], VECS[i][24], VECS[i][23],
                 VECS[i][22:10], 4'h0, 1'b1);
            chk($sformatf("R5/R6 bank_open vec %0d", i), 32'(bank_open), 32'(VECS[i][9:6]));
            chk($sformatf("R3 strobes vec %0d", i),
                32'({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs}), 32'(VECS[i][5:0]));
        end
        chk("R4 open row bank1", 32'(open_row[13 +: 13]), 32'h1ABC);
        chk("R7 read start column", 32'(burst_col), 32'h010);

        // R2: deselected activate of bank 0 leaves everything alone
        step(1'b1, C_ACT, 1'b0, 1'b0, 13'h0555, 4'h0, 1'b1);
        chk("R2 deselect no open", 32'(bank_open), 32'b0010);
        chk("R2 deselect no strobe", 32'(cmd_act), 32'h0);

        // R10 and R7: write with mixed masks
        drive(1'b0, C_WR, 1'b0, 1'b1, 13'h05F3, 4'b0101, 1'b1);
        #1;
        chk("R10 write lanes follow masks", 32'(wr_lane_en), 32'b1010);
        edge_settle();
        chk("R7 write start column", 32'(burst_col), 32'h1F3);
        chk("R7 write bank", 32'(burst_bank), 32'h1);
        chk("R3 write strobe", 32'(cmd_wr), 32'h1);
        drive(1'b0, C_NOP, 1'b0, 1'b0, 13'h0000, 4'b0000, 1'b1);
        #1;
        chk("R10 no write lanes outside write", 32'(wr_lane_en), 32'h0);
        edge_settle();
        chk("R3 strobe lasts one cycle", 32'(cmd_wr), 32'h0);

        // R11: read to closed bank 0, then re-activate open bank 1
        step(1'b0, C_RD, 1'b0, 1'b0, 13'h0077, 4'h0, 1'b1);
        chk("R11 error on closed read", 32'(proto_err), 32'h1);
        chk("R11 column untouched", 32'(burst_col), 32'h1F3);
        chk("R11 banks untouched", 32'(bank_open), 32'b0010);
        step(1'b0, C_ACT, 1'b0, 1'b1, 13'h0000, 4'h0, 1'b1);
        chk("R11 row untouched", 32'(open_row[13 +: 13]), 32'h1ABC);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0000, 4'h0, 1'b1);
        chk("R11 error sticky", 32'(proto_err), 32'h1);

        // R8: cke low makes the next edge invalid
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0000, 4'h0, 1'b0);
        step(1'b0, C_PRE, 1'b0, 1'b0, 13'h0400, 4'h0, 1'b1);
        chk("R8 suspended precharge ignored", 32'(bank_open), 32'b0010);
        chk("R8 no strobe on invalid edge", 32'(cmd_pre), 32'h0);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0000, 4'h0, 1'b1);
        step(1'b0, C_PRE, 1'b0, 1'b1, 13'h0000, 4'h0, 1'b1);
        chk("R6 single-bank precharge bank1", 32'(bank_open), 32'b0000);

        // R9: read mask latency of two valid edges
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b0011, 1'b1);
        chk("R9 not yet applied", 32'(rd_lane_oe), 32'b1111);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b1000, 1'b1);
        chk("R9 first mask after two edges", 32'(rd_lane_oe), 32'b1100);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b0000, 1'b1);
        chk("R9 second mask", 32'(rd_lane_oe), 32'b0111);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b0000, 1'b1);
        chk("R9 all lanes on", 32'(rd_lane_oe), 32'b1111);

        // R8: read-mask pipeline frozen on the invalid edge
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b1111, 1'b0);
        chk("R8 pipe before suspend", 32'(rd_lane_oe), 32'b1111);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b0000, 1'b1);
        chk("R8 pipe frozen", 32'(rd_lane_oe), 32'b1111);
        step(1'b0, C_NOP, 1'b0, 1'b0, 13'h0, 4'b0000, 1'b1);
        chk("R9 pipe resumes", 32'(rd_lane_oe), 32'b0000);

        // R1: reset mid-run clears state and the error
        step(1'b0, C_ACT, 1'b1, 1'b1, 13'h0123, 4'h0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1;
        edge_settle();
        chk("R1 reset closes banks", 32'(bank_open), 32'h0);
        chk("R1 reset clears error", 32'(proto_err), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        edge_settle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule